// File: doc/BRIEF.md
# Interruptible Iterative Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. Signed and unsigned operands are accepted, as are integer and fractional (1.15) formats. The divider works by non-restoring iteration. It does one step on each clock where the step enable is high. A complete division takes exactly 19 such steps: one setup step, sixteen quotient-bit steps, one remainder correction step and one sign-fixing step.

All working state sits in registers that change only when a step is taken. A controller can therefore drop the step enable at any point, for example to run other work, and raise it later. The result is the same as for an uninterrupted division. A start pulse loads fresh operands and resets the step counter, even while an earlier division is still in progress. Division by zero and a quotient that does not fit in 16 bits each raise a flag.

Top module: `idiv_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `div_zero` and `overflow` are all 0.
- R2: In unsigned mode with `op_wide`=1 and `op_frac`=0, the full 32-bit dividend is divided by the divisor, giving quotient = floor(N/D) and remainder = N mod D.
- R3: In signed mode, operands are two's complement. The quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R4: With `op_wide`=0 and `op_frac`=0, only `dividend[15:0]` is used. It is sign-extended in signed mode and zero-extended in unsigned mode, and bits 31:16 have no effect.
- R5: With `op_frac`=1, `dividend[15:0]` is taken as a 1.15 value and multiplied by 2^15 before dividing, so the quotient is in 1.15 format. `op_wide` has no effect in this mode.
- R6: `done` is high for exactly one cycle. It rises immediately after the 19th clock edge at which `step_en` was high following the start edge. Results and flags are valid in that cycle, and `busy` is already 0.
- R7: While `busy`=1 and `step_en`=0, the state does not move: `quotient` and `remainder` stay constant. Any pattern of pauses gives the same final result as an uninterrupted run.
- R8: A `start` pulse during a division discards it. The new operands are loaded and the step count restarts from zero.
- R9: A zero divisor sets `div_zero` at completion and leaves `overflow` at 0.
- R10: With a nonzero divisor, `overflow` is set when the true quotient lies outside 0..65535 (unsigned) or -32768..32767 (signed). A quotient of exactly -32768 is not an overflow.
- R11: `step_en` is ignored on the clock edge where `start` is high, and `start` clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Load operands and mode, restart the step count |
| step_en | input | 1 | Advance one iteration on this edge |
| dividend | input | 32 | Dividend (low half only in 16/16 and fractional modes) |
| divisor | input | 16 | Divisor |
| op_wide | input | 1 | 1: 32/16 division, 0: 16/16 division |
| op_signed | input | 1 | 1: two's complement operands |
| op_frac | input | 1 | 1: fractional 1.15 division |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient, valid from `done` until the next start |
| remainder | output | 16 | Remainder, valid from `done` until the next start |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient did not fit in 16 bits |

## Verification
The start pulse alone never counts as a step. `done`, the quotient, the remainder and both flags are due in the cycle right after the 19th enabled edge that follows the start edge, and the bench samples them at the falling edge of that cycle. The bench counts enabled edges itself. At every falling edge it compares `done` against "this edge was enabled and the count is 19", so a pulse that comes one step early or late is caught under every pause pattern. The flag clearing and `busy` are checked at the falling edge right after the start edge. Output stability is checked across every paused cycle.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef struct packed {
    logic wide;
    logic sgn;
    logic frac;
  } idiv_mode_t;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
  import idiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] raw_hi,
  input  logic [DW-1:0] raw_lo,
  input  logic [DW-1:0] raw_dvs,
  input  idiv_mode_t    mode,
  output logic [DW-1:0] n_hi,
  output logic [DW-1:0] n_lo,
  output logic [DW-1:0] d_mag,
  output logic          q_neg,
  output logic          r_neg,
  output logic          dz,
  output logic          big
);
  localparam int NW = 2 * DW;

  logic [NW-1:0] n_raw;
  logic [NW-1:0] n_mag;
  logic          n_neg;
  logic          d_neg;

  always_comb begin
    if (mode.frac) begin
      n_raw = {{DW{mode.sgn & raw_lo[DW-1]}}, raw_lo} << (DW - 1);
    end else if (mode.wide) begin
      n_raw = {raw_hi, raw_lo};
    end else begin
      n_raw = {{DW{mode.sgn & raw_lo[DW-1]}}, raw_lo};
    end
    n_neg = mode.sgn & n_raw[NW-1];
    n_mag = n_neg ? (~n_raw + 1'b1) : n_raw;
    d_neg = mode.sgn & raw_dvs[DW-1];
    d_mag = d_neg ? (~raw_dvs + 1'b1) : raw_dvs;
    n_hi  = n_mag[NW-1:DW];
    n_lo  = n_mag[DW-1:0];
    dz    = (raw_dvs == '0);
    big   = (n_mag[NW-1:DW] >= d_mag);
    q_neg = n_neg ^ d_neg;
    r_neg = n_neg;
  end
endmodule

// File: rtl/idiv_step.sv
module idiv_step #(
  parameter int DW = 16
) (
  input  logic [DW+1:0] p_in,
  input  logic [DW-1:0] q_in,
  input  logic [DW-1:0] d_in,
  output logic [DW+1:0] p_out,
  output logic [DW-1:0] q_out
);
  logic [DW+1:0] shifted;
  logic [DW+1:0] d_ext;

  always_comb begin
    shifted = {p_in[DW:0], q_in[DW-1]};
    d_ext   = {2'b00, d_in};
    p_out   = p_in[DW+1] ? (shifted + d_ext) : (shifted - d_ext);
    q_out   = {q_in[DW-2:0], ~p_out[DW+1]};
  end
endmodule

// File: rtl/idiv_fix.sv
module idiv_fix #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] q_mag,
  input  logic [DW-1:0] r_mag,
  input  logic          q_neg,
  input  logic          r_neg,
  input  logic          sgn,
  input  logic          big,
  input  logic          dz,
  output logic [DW-1:0] q_res,
  output logic [DW-1:0] r_res,
  output logic          ovf
);
  localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);

  logic s_over;

  always_comb begin
    s_over = sgn & (q_neg ? (q_mag > HALF) : q_mag[DW-1]);
    ovf    = ~dz & (big | s_over);
    q_res  = q_neg ? (~q_mag + 1'b1) : q_mag;
    r_res  = r_neg ? (~r_mag + 1'b1) : r_mag;
  end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step_en,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  input  logic            op_wide,
  input  logic            op_signed,
  input  logic            op_frac,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   quotient,
  output logic [DW-1:0]   remainder,
  output logic            div_zero,
  output logic            overflow
);
  localparam int STEPS = DW + 3;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int PW    = DW + 2;
  localparam logic [CW-1:0] C_SETUP = '0;
  localparam logic [CW-1:0] C_LAST  = CW'(DW);
  localparam logic [CW-1:0] C_CORR  = CW'(DW + 1);
  localparam logic [CW-1:0] C_FIX   = CW'(DW + 2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // state
  logic [PW-1:0] p_q, p_n;
  logic [DW-1:0] q_q, q_n;
  logic [DW-1:0] d_q, d_n;
  idiv_mode_t    m_q, m_n;
  logic          qneg_q, qneg_n, rneg_q, rneg_n;
  logic          big_q, big_n, dz_q, dz_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n;
  logic          dzf_q, dzf_n, ovf_q, ovf_n;

  // datapath pieces
  logic [DW-1:0] s_nhi, s_nlo, s_dmag;
  logic          s_qneg, s_rneg, s_dz, s_big;
  logic [PW-1:0] it_p;
  logic [DW-1:0] it_q;
  logic [DW-1:0] f_q, f_r;
  logic          f_ovf;

  idiv_prep #(.DW(DW)) u_prep (
    .raw_hi (p_q[DW-1:0]), .raw_lo (q_q), .raw_dvs (d_q), .mode (m_q),
    .n_hi   (s_nhi), .n_lo (s_nlo), .d_mag (s_dmag),
    .q_neg  (s_qneg), .r_neg (s_rneg), .dz (s_dz), .big (s_big)
  );

  idiv_step #(.DW(DW)) u_step (
    .p_in (p_q), .q_in (q_q), .d_in (d_q), .p_out (it_p), .q_out (it_q)
  );

  idiv_fix #(.DW(DW)) u_fix (
    .q_mag (q_q), .r_mag (p_q[DW-1:0]), .q_neg (qneg_q), .r_neg (rneg_q),
    .sgn (m_q.sgn), .big (big_q), .dz (dz_q),
    .q_res (f_q), .r_res (f_r), .ovf (f_ovf)
  );

  // next state
  always_comb begin
    p_n = p_q;       q_n = q_q;       d_n = d_q;       m_n = m_q;
    qneg_n = qneg_q; rneg_n = rneg_q; big_n = big_q;   dz_n = dz_q;
    cnt_n = cnt_q;   busy_n = busy_q; done_n = 1'b0;
    dzf_n = dzf_q;   ovf_n = ovf_q;
    if (start) begin
      p_n    = {2'b00, dividend[2*DW-1:DW]};
      q_n    = dividend[DW-1:0];
      d_n    = divisor;
      m_n    = '{wide: op_wide, sgn: op_signed, frac: op_frac};
      cnt_n  = C_SETUP;
      busy_n = 1'b1;
      dzf_n  = 1'b0;
      ovf_n  = 1'b0;
    end else if (busy_q && step_en) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == C_SETUP) begin
        p_n    = {2'b00, s_nhi};
        q_n    = s_nlo;
        d_n    = s_dmag;
        qneg_n = s_qneg;
        rneg_n = s_rneg;
        big_n  = s_big;
        dz_n   = s_dz;
      end else if (cnt_q <= C_LAST) begin
        p_n = it_p;
        q_n = it_q;
      end else if (cnt_q == C_CORR) begin
        if (p_q[PW-1]) p_n = p_q + {2'b00, d_q};
      end else begin
        q_n    = f_q;
        p_n    = {2'b00, f_r};
        dzf_n  = dz_q;
        ovf_n  = f_ovf;
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  // registers carrying control meaning
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dzf_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      dzf_q  <= dzf_n;
      ovf_q  <= ovf_n;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    p_q    <= p_n;
    q_q    <= q_n;
    d_q    <= d_n;
    m_q    <= m_n;
    qneg_q <= qneg_n;
    rneg_q <= rneg_n;
    big_q  <= big_n;
    dz_q   <= dz_n;
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = q_q;
  assign remainder = p_q[DW-1:0];
  assign div_zero  = dzf_q;
  assign overflow  = ovf_q;

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !busy);
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_i)
    busy |-> (cnt_q <= C_FIX));
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_i)
    start |=> (busy && !done && cnt_q == C_SETUP));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !step_en && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(cnt_q)));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !(div_zero && overflow));
  a_r11_flags_cleared: assert property (@(posedge clk) disable iff (!rst_i)
    start |=> (!div_zero && !overflow));
endmodule

// File: tb/idiv_unit_test.sv
module idiv_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        op_wide = 1'b0, op_signed = 1'b0, op_frac = 1'b0;
  logic        busy, done, div_zero, overflow;
  logic [15:0] quotient, remainder;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  idiv_unit uut (
    .clk (clk), .rst_n (rst_n), .start (start), .step_en (step_en),
    .dividend (dividend), .divisor (divisor),
    .op_wide (op_wide), .op_signed (op_signed), .op_frac (op_frac),
    .busy (busy), .done (done), .quotient (quotient), .remainder (remainder),
    .div_zero (div_zero), .overflow (overflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pat(input int pm, input int i);
    case (pm)
      1:       return (i % 3) != 1;
      2:       return !(i >= 5 && i < 15);
      default: return 1'b1;
    endcase
  endfunction

  task automatic expect_of(input logic [31:0] a, input logic [15:0] b,
                           input bit w, input bit s, input bit f,
                           output longint q, output longint r,
                           output bit ez, output bit eo);
    longint n, d;
    if (f)      n = (s ? longint'($signed(a[15:0])) : longint'(a[15:0])) * 32768;
    else if (w) n = s ? longint'($signed(a)) : longint'(a);
    else        n = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
    d = s ? longint'($signed(b)) : longint'(b);
    q = 0; r = 0; ez = (d == 0); eo = 1'b0;
    if (!ez) begin
      q = n / d;
      r = n % d;
      eo = s ? (q > 32767 || q < -32768) : (q > 65535);
    end
  endtask

  task automatic do_start(input logic [31:0] a, input logic [15:0] b,
                          input bit w, input bit s, input bit f);
    @(negedge clk);
    dividend = a; divisor = b; op_wide = w; op_signed = s; op_frac = f;
    start = 1'b1; step_en = 1'b1;   // step_en here must be ignored (R11)
    @(negedge clk);
    start = 1'b0; step_en = 1'b0;
    chk(busy === 1'b1 && div_zero === 1'b0 && overflow === 1'b0,
        "R11 start clears flags, sets busy", {busy, div_zero, overflow}, 3'b100);
  endtask

  task automatic run_div(input string tag, input logic [31:0] a, input logic [15:0] b,
                         input bit w, input bit s, input bit f, input int pm);
    longint eq, er;
    bit ez, eo, seen;
    int n, terr, herr;
    expect_of(a, b, w, s, f, eq, er, ez, eo);
    do_start(a, b, w, s, f);
    n = 0; seen = 1'b0; terr = 0; herr = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      bit en;
      logic [15:0] qb, rb;
      en = pat(pm, i);
      step_en = en;
      qb = quotient; rb = remainder;
      @(posedge clk);
      if (en) n++;
      @(negedge clk);
      if (!en && (quotient !== qb || remainder !== rb)) herr++;
      if (done !== (en && n == 19)) terr++;
      if (done === 1'b1) seen = 1'b1;
    end
    chk(seen && terr == 0 && busy === 1'b0, {tag, " R6 done after 19th step"}, n, 19);
    if (pm != 0) chk(herr == 0, {tag, " R7 outputs held while paused"}, herr, 0);
    chk(div_zero === ez, {tag, " R9 div_zero flag"}, div_zero, ez);
    chk(overflow === eo, {tag, " R10 overflow flag"}, overflow, eo);
    if (!ez && !eo) begin
      chk(quotient === eq[15:0], {tag, " quotient"}, quotient, eq[15:0]);
      chk(remainder === er[15:0], {tag, " remainder"}, remainder, er[15:0]);
    end
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 done lasts one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD * 2);
    chk({busy, done, div_zero, overflow} === 4'b0000, "R1 state during reset",
        {busy, done, div_zero, overflow}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, div_zero, overflow} === 4'b0000, "R1 state after release",
        {busy, done, div_zero, overflow}, 0);
  endtask

  task automatic t_unsigned;
    run_div("R2 u32 a", 32'h1234_5678, 16'h5678, 1, 0, 0, 0);
    run_div("R2 u32 max", 32'hFFFE_FFFF, 16'hFFFF, 1, 0, 0, 0);
    run_div("R2 u32 small", 32'd99, 16'd100, 1, 0, 0, 0);
  endtask

  task automatic t_signed;
    run_div("R3 s32 neg/pos", 32'(-1000000), 16'd123, 1, 1, 0, 0);
    run_div("R3 s32 pos/neg", 32'd1000000, 16'(-123), 1, 1, 0, 0);
    run_div("R3 s32 neg/neg", 32'(-1000000), 16'(-123), 1, 1, 0, 0);
  endtask

  task automatic t_narrow;
    run_div("R4 s16", 32'hDEAD_FF9C, 16'd7, 0, 1, 0, 0);
    run_div("R4 u16", 32'hDEAD_FF9C, 16'd7, 0, 0, 0, 0);
  endtask

  task automatic t_frac;
    run_div("R5 frac pos", 32'h0000_2000, 16'h4000, 0, 1, 1, 0);
    run_div("R5 frac neg wide", 32'hFFFF_E000, 16'h4000, 1, 1, 1, 0);
    run_div("R5 frac -1/-1", 32'h0000_8000, 16'h8000, 0, 1, 1, 0);
  endtask

  task automatic t_pause;
    run_div("R7 pause sparse", 32'(-987654), 16'd321, 1, 1, 0, 1);
    run_div("R7 pause long", 32'hABCD_1234, 16'hC001, 1, 0, 0, 2);
  endtask

  task automatic t_restart;
    do_start(32'd5000, 16'd3, 1, 0, 0);
    for (int i = 0; i < 7; i++) begin
      step_en = 1'b1;
      @(negedge clk);
    end
    step_en = 1'b0;
    run_div("R8 restart", 32'h0003_0000, 16'd7, 1, 0, 0, 1);
  endtask

  task automatic t_divzero;
    run_div("R9 zero u", 32'h0001_0000, 16'd0, 1, 0, 0, 0);
    run_div("R9 zero s", 32'(-5), 16'd0, 0, 1, 0, 0);
  endtask

  task automatic t_overflow;
    run_div("R10 u32 over", 32'h0005_0000, 16'd5, 1, 0, 0, 0);
    run_div("R10 u32 edge", 32'h0004_FFFF, 16'd5, 1, 0, 0, 0);
    run_div("R10 s16 over", 32'h0000_8000, 16'hFFFF, 0, 1, 0, 0);
    run_div("R10 s32 min ok", 32'(-229376), 16'd7, 1, 1, 0, 0);
    run_div("R10 s32 pos over", 32'd229376, 16'd7, 1, 1, 0, 0);
  endtask

  initial begin
    t_reset;
    t_unsigned;
    t_signed;
    t_narrow;
    t_frac;
    t_pause;
    t_restart;
    t_divzero;
    t_overflow;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule